// File: doc/BRIEF.md
# Fixed-Length Button Pulse Generator

This block converts a single-bit button level into an output pulse of a fixed number of clock cycles. It is a clocked Moore machine: the output depends on the stored state alone. When the machine is idle and sees the button high on a rising clock edge, it raises its output for exactly `PULSE_LEN` cycles. During that window the button is not looked at. Holding the button, releasing it early, or letting it chatter therefore cannot shorten, stretch or restart a pulse.

For pulse lengths of two and three the machine is an explicit two-bit state register. Idle is encoded 00 and the active states count upward from 01. Any other length uses a loadable down-counter with the same behaviour at the ports. An asynchronous active-low reset clears the machine at once. Its release is synchronised inside the block, so the first button sample is taken on the third rising edge after release.

Top module: `pulse_one_shot`

## Requirements
- R1: While `rst_n` is low, `pulse_o` is low without waiting for a clock edge, and the machine returns to idle. This holds even when reset arrives in the middle of a pulse.
- R2: In idle, a rising edge that samples `btn_i` low leaves `pulse_o` low.
- R3: In idle, a rising edge that samples `btn_i` high raises `pulse_o` immediately after that edge.
- R4: Each trigger gives exactly `PULSE_LEN` consecutive high cycles of `pulse_o`, then a low cycle. For lengths 2 and 3 the state bits encode idle as 00 and the active states as 01, 10 and 11, and `pulse_o` is the OR of the two bits. Other lengths use a down-counter with identical port behaviour.
- R5: Any value of `btn_i` while `pulse_o` is high has no effect on the pulse.
- R6: A button held high continuously gives a repeating pattern: `PULSE_LEN` cycles high, then exactly one cycle low.
- R7: After `rst_n` rises, the first two rising edges ignore `btn_i`. The first edge that can trigger a pulse is the third one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| btn_i | input | 1 | Button level, assumed already synchronous to `clk` |
| pulse_o | output | 1 | Fixed-length pulse, derived from state only |

## Verification
The bound checker enforces several behaviours on every cycle:
- the output is low whenever the synchronised reset is active;
- an idle machine follows the button on the next edge;
- a running pulse never ends before `PULSE_LEN` cycles, whatever the button does;
- a high run never exceeds `PULSE_LEN` and never ends short of it.

Some behaviours only the bench scenarios can show, because they depend on a stimulus history. These are the N-high/one-low rhythm under a held button, the immediate drop when reset arrives mid-pulse, and the two ignored edges after reset release. The bench runs all three length variants side by side against a reference model of the required timing.

// File: rtl/pulse_one_shot_pkg.sv
package pulse_one_shot_pkg;

  // Two-bit encoding used by the explicit short-pulse machine.
  localparam logic [1:0] ST_IDLE  = 2'b00;
  localparam logic [1:0] ST_HOLD1 = 2'b01;
  localparam logic [1:0] ST_HOLD2 = 2'b10;
  localparam logic [1:0] ST_HOLD3 = 2'b11;

  // Counter width able to hold the value len.
  function automatic int unsigned cnt_width(input int unsigned len);
    return (len < 2) ? 1 : $clog2(len + 1);
  endfunction

endpackage

// File: rtl/pulse_rst_sync.sv
module pulse_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pulse_fsm_enc.sv
module pulse_fsm_enc
  import pulse_one_shot_pkg::*;
#(
  parameter int unsigned LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o
);
  logic [1:0] state_q;
  logic [1:0] state_d;
  logic       state_en;

  generate
    if (LEN == 3) begin : g_len3
      // Gate-level next state for four states counting 00 -> 01 -> 10 -> 11 -> 00.
      always_comb begin
        state_d[1] = state_q[1] ^ state_q[0];
        state_d[0] = (~state_q[1] & ~state_q[0] & trig_i) | (state_q[1] & ~state_q[0]);
      end
    end else begin : g_len2
      // Three states: idle, first and last active cycle.
      always_comb begin
        case (state_q)
          ST_IDLE:  state_d = trig_i ? ST_HOLD1 : ST_IDLE;
          ST_HOLD1: state_d = ST_HOLD2;
          ST_HOLD2: state_d = ST_IDLE;
          default:  state_d = ST_IDLE;
        endcase
      end
    end
  endgenerate

  // Register only moves when active or when a trigger arrives in idle.
  always_comb begin
    state_en = (state_q != ST_IDLE) || trig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (state_en) state_q <= state_d;
  end

  assign active_o = state_q[1] | state_q[0];
endmodule

// File: rtl/pulse_down_cnt.sv
module pulse_down_cnt
  import pulse_one_shot_pkg::*;
#(
  parameter int unsigned LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned   CW   = cnt_width(LEN);
  localparam logic [CW-1:0] LOAD = CW'(LEN);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          busy;
  logic          cnt_en;

  always_comb begin
    busy   = (cnt_q != '0);
    cnt_en = busy || trig_i;
    cnt_d  = busy ? (cnt_q - ONE) : LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = busy;
endmodule

// File: rtl/pulse_one_shot.sv
module pulse_one_shot #(
  parameter int unsigned PULSE_LEN  = 3,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic pulse_o
);
  logic rst_sync_n;
  logic active;

  pulse_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  generate
    if (PULSE_LEN == 2 || PULSE_LEN == 3) begin : g_enc
      pulse_fsm_enc #(.LEN(PULSE_LEN)) u_core (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .trig_i   (btn_i),
        .active_o (active)
      );
    end else begin : g_cnt
      pulse_down_cnt #(.LEN(PULSE_LEN)) u_core (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .trig_i   (btn_i),
        .active_o (active)
      );
    end
  endgenerate

  assign pulse_o = active;
endmodule

// File: rtl/pulse_one_shot_chk.sv
module pulse_one_shot_chk #(
  parameter int unsigned PULSE_LEN = 3
) (
  input logic clk,
  input logic rst_sync_n,
  input logic btn_i,
  input logic pulse_o
);
  localparam int unsigned HW = $clog2(PULSE_LEN + 2) + 1;

  // Number of consecutive high cycles seen before the current one.
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  hi_cnt <= '0;
    else if (pulse_o) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  p_reset_low_r1: assert property (@(posedge clk)
    !rst_sync_n |-> !pulse_o);

  p_idle_stay_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pulse_o && !btn_i) |=> !pulse_o);

  p_trigger_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pulse_o && btn_i) |=> pulse_o);

  p_max_len_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pulse_o |-> (int'(hi_cnt) < int'(PULSE_LEN)));

  p_full_len_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pulse_o && hi_cnt != '0) |-> (int'(hi_cnt) == int'(PULSE_LEN)));

  p_no_cut_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pulse_o && (int'(hi_cnt) + 1 < int'(PULSE_LEN))) |=> pulse_o);
endmodule

bind pulse_one_shot pulse_one_shot_chk #(.PULSE_LEN(PULSE_LEN)) u_pulse_one_shot_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .btn_i      (btn_i),
  .pulse_o    (pulse_o)
);

// File: tb/pulse_one_shot_bench.sv
`timescale 1ns/1ps
module pulse_one_shot_bench;
  localparam int LEN_A = 3;
  localparam int LEN_B = 2;
  localparam int LEN_C = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic btn;
  logic p_a, p_b, p_c;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  int   m [3];
  int   rel;
  int   tally [3];

  always #4 clk = ~clk;

  pulse_one_shot u_pulse_one_shot (.clk(clk), .rst_n(rst_n), .btn_i(btn), .pulse_o(p_a));
  pulse_one_shot #(.PULSE_LEN(LEN_B)) u_pulse_one_shot_len2 (.clk(clk), .rst_n(rst_n), .btn_i(btn), .pulse_o(p_b));
  pulse_one_shot #(.PULSE_LEN(LEN_C)) u_pulse_one_shot_len5 (.clk(clk), .rst_n(rst_n), .btn_i(btn), .pulse_o(p_c));

  function automatic int len_of(input int k);
    return (k == 0) ? LEN_A : (k == 1) ? LEN_B : LEN_C;
  endfunction

  function automatic logic out_of(input int k);
    return (k == 0) ? p_a : (k == 1) ? p_b : p_c;
  endfunction

  // Reference model: remaining high cycles per instance, two ignored edges after release.
  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0;
      for (int k = 0; k < 3; k++) m[k] = 0;
    end else if (rel < 2) begin
      rel = rel + 1;
      for (int k = 0; k < 3; k++) m[k] = 0;
    end else begin
      for (int k = 0; k < 3; k++)
        m[k] = (m[k] != 0) ? m[k] - 1 : (btn ? len_of(k) : 0);
    end
  end

  task automatic check_val(input string tag, input int k, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s len=%0d actual=%0d expected=%0d at %0t", tag, len_of(k), act, exp, $time);
    end
  endtask

  task automatic step(input logic b, input logic r, input string tag);
    btn   = b;
    rst_n = r;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check_val(tag, k, int'(out_of(k)), int'(rst_n && m[k] != 0));
      tally[k] += int'(out_of(k));
    end
  endtask

  task automatic clear_tally();
    for (int k = 0; k < 3; k++) tally[k] = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed  = $urandom(32'd20240611);
    rst_n = 1'b0;
    btn   = 1'b0;
    clear_tally();

    // R1: reset state, outputs low
    repeat (3) step(1'b1, 1'b0, "R1");
    for (int k = 0; k < 3; k++) check_val("R1 reset", k, int'(out_of(k)), 0);

    // R7: button high on the first two edges after release is ignored
    clear_tally();
    step(1'b1, 1'b1, "R7");
    step(1'b1, 1'b1, "R7");
    repeat (4) step(1'b0, 1'b1, "R7");
    for (int k = 0; k < 3; k++) check_val("R7 release", k, tally[k], 0);

    // R2: idle with button low
    clear_tally();
    repeat (5) step(1'b0, 1'b1, "R2");
    for (int k = 0; k < 3; k++) check_val("R2 idle", k, tally[k], 0);

    // R3 / R4: single-cycle press
    clear_tally();
    step(1'b1, 1'b1, "R3");
    for (int k = 0; k < 3; k++) check_val("R3 start", k, int'(out_of(k)), 1);
    repeat (8) step(1'b0, 1'b1, "R4");
    for (int k = 0; k < 3; k++) check_val("R4 length", k, tally[k], len_of(k));

    // R6: held press over 24 cycles, N high then one low
    clear_tally();
    repeat (24) step(1'b1, 1'b1, "R6");
    for (int k = 0; k < 3; k++)
      check_val("R6 held", k, tally[k], (24 / (len_of(k) + 1)) * len_of(k));
    repeat (8) step(1'b0, 1'b1, "R6");

    // R5: bouncing button during the window
    clear_tally();
    step(1'b1, 1'b1, "R5");
    step(1'b0, 1'b1, "R5");
    step(1'b1, 1'b1, "R5");
    step(1'b0, 1'b1, "R5");
    repeat (6) step(1'b0, 1'b1, "R5");
    for (int k = 0; k < 3; k++) check_val("R5 bounce", k, tally[k], len_of(k));

    // R1: reset in the middle of a pulse drops the output at once
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, "R1");
    btn   = 1'b0;
    rst_n = 1'b0;
    #1;
    for (int k = 0; k < 3; k++) check_val("R1 mid-pulse", k, int'(out_of(k)), 0);
    step(1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, "R1");
    repeat (4) step(1'b0, 1'b1, "R1");

    // R4: random button activity with occasional resets
    for (int i = 0; i < 3000; i++) begin
      logic b;
      logic r;
      b = (($urandom % 3) == 0);
      r = (($urandom % 300) != 0);
      step(b, r, "R4");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule